// File: doc/BRIEF.md
# Burst Sequential Access Slave

This block is a word-wide memory slave that serves multi-word transfers at consecutive addresses while the address is sent only once. A master starts an access by raising the request strobe with a byte address and a direction. If it also raises the burst-request line and the slave agrees, the slave raises burst-acknowledge. From then on the slave keeps its own word pointer, and every further cycle in which the master holds both the strobe and burst-request moves one more word. The address input is not looked at while the burst continues.

The slave follows the life of each burst. The master pauses a burst by dropping the strobe while it keeps burst-request high, and it resumes the burst without sending the address again. It ends the burst by dropping burst-request. The slave itself stops a burst when the next word would fall into a new 1 KB page, and after an access outside the populated memory. In both cases a fresh address must be sent before any further transfer. Outputs are registered, so the response to the inputs of one cycle appears after the next clock edge.

Top module: `burst_seq_slave`

## Requirements
- R1: While reset is held and afterwards until the first access, rdy_o, err_o and burst_ack_o are 0, and burst_state_o is 0 (idle). The state codes are 0 idle, 1 active, 2 suspended, 3 preempted and 4 cancelled.
- R2: When req_i is 1 with burst_req_i at 0 and the block is not in a burst, the slave moves one word at addr_i. rd_wr_i at 1 reads and rd_wr_i at 0 writes wdata_i. After the next edge rdy_o is 1, a read returns the stored word on rdata_o, burst_ack_o is 0 and the state is idle. An access can be made on every cycle.
- R3: A start with burst_req_i at 1 at an address that is not the last word of a 1 KB page returns burst_ack_o at 1 together with the first rdy_o, and the state becomes active. burst_ack_o is only ever 1 after a cycle in which burst_req_i was 1.
- R4: During a burst, each cycle with req_i and burst_req_i both at 1 moves the word 4 bytes above the previous one, whatever the value of addr_i.
- R5: The direction latched at the start of a burst applies to every word of it. rd_wr_i is ignored until the burst ends.
- R6: During a burst, a cycle with req_i at 0 and burst_req_i at 1 moves no word. It gives state 2 with burst_ack_o still at 1, and the next cycle with req_i at 1 continues at the next sequential word.
- R7: During an active or suspended burst, a cycle with burst_req_i at 0 ends the burst with no transfer. rdy_o is 0 and the state is idle after that edge.
- R8: The word that is the last one of a 1 KB page is still transferred, but it ends the burst: burst_ack_o drops to 0 and the state becomes 3. The next req_i starts afresh from addr_i, and dropping burst_req_i returns the slave to idle.
- R9: An access whose word index is DEPTH or more raises err_o for one cycle with no rdy_o and no write, and gives state 4. The slave then makes no transfer until req_i brings a new address. Dropping burst_req_i without req_i returns it to idle.
- R10: rdy_o and err_o are never 1 in the same cycle.
- R11: A start with burst_req_i at 1 at the last word of a 1 KB page is served as a single access: rdy_o is 1, burst_ack_o is 0 and the state stays idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| req_i | input | 1 | Request strobe: start an access, or move the next burst word |
| addr_i | input | AW | Byte address, sampled only when an access starts |
| rd_wr_i | input | 1 | 1 for read, 0 for write, sampled when an access starts |
| burst_req_i | input | 1 | Master asks for a burst, or holds one open |
| wdata_i | input | DW | Write data for the word moved in this cycle |
| burst_ack_o | output | 1 | Slave keeps a burst open |
| rdy_o | output | 1 | One word was moved in the previous cycle |
| err_o | output | 1 | The access of the previous cycle failed |
| rdata_o | output | DW | Read data that goes with rdy_o |
| burst_state_o | output | 3 | Burst condition: 0 idle, 1 active, 2 suspended, 3 preempted, 4 cancelled |

## Verification
Two things can fall in the same cycle. A word transfer can coincide with the end of the burst at a page boundary, and the granting of a burst coincides with the completion of its first word. The bench sweeps write bursts across every word of memory, so each page end arrives while a transfer is in flight. There it checks that the last word is delivered with rdy_o set while burst_ack_o falls and the state turns preempted, and that the contents read back afterwards are correct. Read bursts with suspension gaps starting near the page end, and a burst request at the last word of a page, show whether the slave grants the burst, or refuses it, in the same cycle as the data.

// File: rtl/bsa_pkg.sv
package bsa_pkg;

    typedef enum logic [2:0] {
        BS_IDLE    = 3'd0,
        BS_ACTIVE  = 3'd1,
        BS_SUSP    = 3'd2,
        BS_PREEMPT = 3'd3,
        BS_CANCEL  = 3'd4
    } bst_e;

    typedef struct packed {
        logic start;
        logic cont;
        logic ok;
        logic rd;
    } xfer_t;

    localparam int unsigned WORD_BYTES = 4;

    function automatic logic last_in_page(input logic [31:0] a, input int unsigned plg);
        logic [31:0] m;
        m = (32'd1 << (plg - 2)) - 32'd1;
        return ((a >> 2) & m) == m;
    endfunction

endpackage

// File: rtl/bsa_addr_ctr.sv
module bsa_addr_ctr #(
    parameter int AW = 12
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          adv,
    input  logic [AW-1:0] base,
    output logic [AW-1:0] ptr
);
    always_ff @(posedge clk) begin
        if (rst)
            ptr <= '0;
        else if (adv)
            ptr <= {base[AW-1:2], 2'b00} + AW'(bsa_pkg::WORD_BYTES);
    end
endmodule

// File: rtl/bsa_store.sv
module bsa_store #(
    parameter int DW    = 32,
    parameter int DEPTH = 512,
    parameter int IW    = 9
) (
    input  logic          clk,
    input  logic          we,
    input  logic          re,
    input  logic [IW-1:0] idx,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we)
            mem[idx] <= wdata;
        if (re)
            rdata <= mem[idx];
    end
endmodule

// File: rtl/bsa_ctrl.sv
module bsa_ctrl
    import bsa_pkg::*;
#(
    parameter int AW      = 12,
    parameter int DEPTH   = 512,
    parameter int PAGE_LG = 10
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req_i,
    input  logic [AW-1:0] addr_i,
    input  logic          rd_wr_i,
    input  logic          burst_req_i,
    input  logic [AW-1:0] ptr_i,
    output logic [AW-1:0] cur_addr_o,
    output logic          adv_o,
    output logic          we_o,
    output logic          re_o,
    output logic          ack_o,
    output logic          rdy_o,
    output logic          err_o,
    output logic [2:0]    state_o
);
    bst_e  st_q, st_d;
    logic  dir_q;
    logic  ack_d;
    logic  in_burst, susp, term, last;
    xfer_t x;

    always_comb begin
        in_burst   = (st_q == BS_ACTIVE) || (st_q == BS_SUSP);
        x.start    = !in_burst && req_i;
        x.cont     = in_burst && burst_req_i && req_i;
        susp       = in_burst && burst_req_i && !req_i;
        term       = in_burst && !burst_req_i;
        cur_addr_o = x.start ? addr_i : ptr_i;
        x.rd       = x.start ? rd_wr_i : dir_q;
        x.ok       = {2'b00, cur_addr_o[AW-1:2]} < AW'(DEPTH);
        last       = last_in_page(32'(cur_addr_o), PAGE_LG);
        adv_o      = (x.start || x.cont) && x.ok;
        we_o       = adv_o && !x.rd;
        re_o       = adv_o && x.rd;
    end

    always_comb begin
        st_d  = st_q;
        ack_d = 1'b0;
        if ((x.start || x.cont) && !x.ok) begin
            st_d = BS_CANCEL;
        end else if (x.start) begin
            if (burst_req_i && !last) begin
                st_d  = BS_ACTIVE;
                ack_d = 1'b1;
            end else begin
                st_d = BS_IDLE;
            end
        end else if (x.cont) begin
            if (last) begin
                st_d = BS_PREEMPT;
            end else begin
                st_d  = BS_ACTIVE;
                ack_d = 1'b1;
            end
        end else if (susp) begin
            st_d  = BS_SUSP;
            ack_d = 1'b1;
        end else if (term) begin
            st_d = BS_IDLE;
        end else if ((st_q == BS_PREEMPT || st_q == BS_CANCEL) && !burst_req_i) begin
            st_d = BS_IDLE;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= BS_IDLE;
            ack_o <= 1'b0;
            rdy_o <= 1'b0;
            err_o <= 1'b0;
            dir_q <= 1'b1;
        end else begin
            st_q  <= st_d;
            ack_o <= ack_d;
            rdy_o <= adv_o;
            err_o <= (x.start || x.cont) && !x.ok;
            if (x.start)
                dir_q <= rd_wr_i;
        end
    end

    assign state_o = st_q;
endmodule

// File: rtl/burst_seq_slave.sv
module burst_seq_slave #(
    parameter int AW         = 12,
    parameter int DW         = 32,
    parameter int DEPTH      = 512,
    parameter int PAGE_BYTES = 1024
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req_i,
    input  logic [AW-1:0] addr_i,
    input  logic          rd_wr_i,
    input  logic          burst_req_i,
    input  logic [DW-1:0] wdata_i,
    output logic          burst_ack_o,
    output logic          rdy_o,
    output logic          err_o,
    output logic [DW-1:0] rdata_o,
    output logic [2:0]    burst_state_o
);
    localparam int PAGE_LG = $clog2(PAGE_BYTES);
    localparam int IW      = $clog2(DEPTH);

    logic [AW-1:0] ptr, cur_addr;
    logic          adv, we, re;

    bsa_ctrl #(.AW(AW), .DEPTH(DEPTH), .PAGE_LG(PAGE_LG)) u_ctrl (
        .clk(clk), .rst(rst), .req_i(req_i), .addr_i(addr_i), .rd_wr_i(rd_wr_i),
        .burst_req_i(burst_req_i), .ptr_i(ptr), .cur_addr_o(cur_addr), .adv_o(adv),
        .we_o(we), .re_o(re), .ack_o(burst_ack_o), .rdy_o(rdy_o), .err_o(err_o),
        .state_o(burst_state_o)
    );

    bsa_addr_ctr #(.AW(AW)) u_ptr (
        .clk(clk), .rst(rst), .adv(adv), .base(cur_addr), .ptr(ptr)
    );

    bsa_store #(.DW(DW), .DEPTH(DEPTH), .IW(IW)) u_mem (
        .clk(clk), .we(we), .re(re), .idx(cur_addr[IW+1:2]),
        .wdata(wdata_i), .rdata(rdata_o)
    );
endmodule

// File: rtl/bsa_chk.sv
module bsa_chk (
    input logic       clk,
    input logic       rst,
    input logic       req_i,
    input logic       burst_req_i,
    input logic       burst_ack_o,
    input logic       rdy_o,
    input logic       err_o,
    input logic [2:0] burst_state_o
);
    AST_ACK_AFTER_BREQ: assert property (@(posedge clk) disable iff (rst)
        burst_ack_o |-> $past(burst_req_i)); // R3
    AST_RDY_ERR_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(rdy_o && err_o)); // R10
    AST_ERR_CANCEL: assert property (@(posedge clk) disable iff (rst)
        err_o |-> burst_state_o == 3'd4); // R9
    AST_CANCEL_HOLD: assert property (@(posedge clk) disable iff (rst)
        (burst_state_o == 3'd4 && !req_i) |=> !rdy_o); // R9
    AST_SUSP_QUIET: assert property (@(posedge clk) disable iff (rst)
        burst_state_o == 3'd2 |-> (!rdy_o && burst_ack_o)); // R6
    AST_TERM_IDLE: assert property (@(posedge clk) disable iff (rst)
        ((burst_state_o == 3'd1 || burst_state_o == 3'd2) && !burst_req_i)
        |=> (burst_state_o == 3'd0 && !rdy_o)); // R7
    AST_PREEMPT_NOACK: assert property (@(posedge clk) disable iff (rst)
        burst_state_o == 3'd3 |-> !burst_ack_o); // R8
endmodule

bind burst_seq_slave bsa_chk u_chk (
    .clk(clk), .rst(rst), .req_i(req_i), .burst_req_i(burst_req_i),
    .burst_ack_o(burst_ack_o), .rdy_o(rdy_o), .err_o(err_o),
    .burst_state_o(burst_state_o)
);

// File: tb/sim_burst_seq_slave.sv
module sim_burst_seq_slave;
    localparam int CLK_P = 10;
    localparam int NW    = 512;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_i = 1'b0, rd_wr_i = 1'b1, burst_req_i = 1'b0;
    logic [11:0] addr_i = '0;
    logic [31:0] wdata_i = '0;
    logic        burst_ack_o, rdy_o, err_o;
    logic [31:0] rdata_o;
    logic [2:0]  burst_state_o;

    int n_chk = 0;
    int n_fail = 0;
    logic [31:0] emem [NW];

    always #(CLK_P/2) clk = ~clk;

    burst_seq_slave u0 (
        .clk(clk), .rst(rst), .req_i(req_i), .addr_i(addr_i), .rd_wr_i(rd_wr_i),
        .burst_req_i(burst_req_i), .wdata_i(wdata_i), .burst_ack_o(burst_ack_o),
        .rdy_o(rdy_o), .err_o(err_o), .rdata_o(rdata_o), .burst_state_o(burst_state_o)
    );

    function automatic logic [31:0] pat(input int i);
        return (32'(i) * 32'h9E3779B1) ^ 32'h5A5A0000;
    endfunction

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic step(input logic rq, input logic [11:0] a, input logic rw,
                        input logic br, input logic [31:0] wd);
        req_i = rq; addr_i = a; rd_wr_i = rw; burst_req_i = br; wdata_i = wd;
        @(posedge clk);
        #1;
    endtask

    task automatic expect_out(input string tag, input logic e_rdy, input logic e_err,
                              input logic e_ack, input logic [2:0] e_st,
                              input logic dchk, input logic [31:0] e_dat);
        chk({tag, " rdy"}, 32'(rdy_o), 32'(e_rdy));
        chk({tag, " err"}, 32'(err_o), 32'(e_err));
        chk({tag, " ack"}, 32'(burst_ack_o), 32'(e_ack));
        chk({tag, " state"}, 32'(burst_state_o), 32'(e_st));
        chk("R10 rdy/err exclusive", 32'(rdy_o && err_o), 32'd0);
        if (dchk) chk({tag, " data"}, rdata_o, e_dat);
    endtask

    initial begin
        #(CLK_P * 150000);
        n_fail++;
        $display("FAIL watchdog expired got running expected done");
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (2) @(posedge clk);
        #1;
        expect_out("R1 reset held", 0, 0, 0, 3'd0, 0, 0);
        rst = 1'b0;
        step(0, 0, 1, 0, 0);
        expect_out("R1 after reset", 0, 0, 0, 3'd0, 0, 0);

        // R4 R5 R8: write bursts over both pages, addr_i and rd_wr_i garbage
        for (int pg = 0; pg < 2; pg++) begin
            for (int j = 0; j < 256; j++) begin
                int w;
                w = pg * 256 + j;
                emem[w] = pat(w);
                if (j == 0) step(1, 12'(w * 4), 0, 1, pat(w));
                else        step(1, 12'hFFC, 1, 1, pat(w));
                expect_out(j == 255 ? "R8 page end" : "R4 R5 write burst",
                           1, 0, j != 255, j == 255 ? 3'd3 : 3'd1, 0, 0);
            end
        end
        step(0, 0, 1, 0, 0);
        expect_out("R8 preempt to idle", 0, 0, 0, 3'd0, 0, 0);

        // R3 R4 R6 R7 R8: read bursts with suspension gaps
        foreach (emem[i]) begin end
        for (int si = 0; si < 5; si++) begin
            int s, w;
            logic pre;
            s = (si == 0) ? 0 : (si == 1) ? 37 : (si == 2) ? 250 : (si == 3) ? 300 : 500;
            step(1, 12'(s * 4), 1, 1, 0);
            expect_out("R3 burst start", 1, 0, 1, 3'd1, 1, emem[s]);
            w = s;
            pre = 1'b0;
            for (int k = 1; k < 16 && !pre; k++) begin
                if (k % 4 == 3) begin
                    step(0, 12'h123, 0, 1, 0);
                    expect_out("R6 suspend", 0, 0, 1, 3'd2, 0, 0);
                end else begin
                    w++;
                    step(1, 12'hABC, 0, 1, 32'hBAD0BAD0);
                    pre = (w % 256 == 255);
                    expect_out(pre ? "R8 read page end" : "R4 R6 read burst",
                               1, 0, !pre, pre ? 3'd3 : 3'd1, 1, emem[w]);
                end
            end
            step(0, 0, 1, 0, 0);
            expect_out("R7 terminate", 0, 0, 0, 3'd0, 0, 0);
        end

        // R2: single accesses, back to back
        for (int i = 0; i < 4; i++) begin
            int w;
            w = (i == 0) ? 3 : (i == 1) ? 100 : (i == 2) ? 256 : 511;
            step(1, 12'(w * 4), 1, 0, 0);
            expect_out("R2 single read", 1, 0, 0, 3'd0, 1, emem[w]);
        end
        step(1, 12'(5 * 4), 0, 0, 32'hCAFE0005);
        emem[5] = 32'hCAFE0005;
        expect_out("R2 single write", 1, 0, 0, 3'd0, 0, 0);
        step(1, 12'(5 * 4), 1, 0, 0);
        expect_out("R2 read back", 1, 0, 0, 3'd0, 1, emem[5]);

        // R11: burst request at last word of a page
        step(1, 12'(255 * 4), 1, 1, 0);
        expect_out("R11 refuse burst", 1, 0, 0, 3'd0, 1, emem[255]);
        step(0, 0, 1, 0, 0);
        expect_out("R11 idle", 0, 0, 0, 3'd0, 0, 0);

        // R9: out-of-range access (word 512 would alias word 0)
        step(1, 12'd2048, 0, 1, 32'hDEADDEAD);
        expect_out("R9 error", 0, 1, 0, 3'd4, 0, 0);
        for (int k = 0; k < 3; k++) begin
            step(0, 0, 1, 1, 0);
            expect_out("R9 cancel hold", 0, 0, 0, 3'd4, 0, 0);
        end
        step(1, 0, 1, 0, 0);
        expect_out("R9 restart, memory unchanged", 1, 0, 0, 3'd0, 1, emem[0]);
        step(1, 12'd3000, 1, 0, 0);
        expect_out("R9 error read", 0, 1, 0, 3'd4, 0, 0);
        step(0, 0, 1, 0, 0);
        expect_out("R9 cancel to idle", 0, 0, 0, 3'd0, 0, 0);

        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule